// File: doc/BRIEF.md
# PLL Ratio Reducer Engine

This block turns a requested output frequency and a reference frequency, both integers in hertz, into the two integer ratio terms a PLL needs. The first is a feedback multiplier N of at most 12 bits. The second is a reference divider M of at most 9 bits. When the request is at or below the reference, the block selects bypass. Otherwise it pulls the request into the legal VCO window. It then removes the common factor of the two frequencies with a sequential binary GCD and forms the two quotients on one shared bit-serial divider. Last, it halves N and M together until both fit their fields, and it never lets either term reach zero.

A request starts with a one-cycle `start` pulse. `busy` stays high while the block works, and `done` pulses for one cycle when the results are valid. The results stay on the outputs until the next request completes. Along with N and M, the block reports the frequency these terms actually produce, which is reference × N / M rounded down, or the reference itself in bypass.

Top module: `pll_ratio_reducer`

## Requirements
- R1: When the requested rate is less than or equal to the reference rate, the result is bypass=1, N=0, M=0, and the achieved rate equals the reference rate.
- R2: When the requested rate exceeds the reference rate, it is first clamped to the window 80,000,000 to 230,000,000 Hz, and this clamped value is the target used for all further steps.
- R3: The target and the reference are reduced by g = gcd(target, reference), which gives N = target / g and M = reference / g before any fitting.
- R4: While N > 4095 or M > 511, N and M are both shifted right by one bit in the same step, and the shifting stops as soon as both are in range.
- R5: After fitting, an N of 0 becomes 1 and an M of 0 becomes 1. A non-bypass result never has N or M equal to zero.
- R6: For a non-bypass result, the achieved rate output equals floor(reference × N / M) computed from the final N and M.
- R7: `busy` is high from the cycle after an accepted `start` until `done` is reported. `done` is high for exactly one cycle, and the result outputs hold their values until the next result.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running request completes with its own inputs, and no second result follows.
- R9: After reset, `busy`, `done` and `bypass` are 0, and N, M and the achieved rate are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| req_hz | input | 32 | Requested output frequency in Hz |
| src_hz | input | 32 | Reference frequency in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| bypass | output | 1 | Bypass selected |
| n_out | output | 12 | Feedback multiplier N |
| m_out | output | 9 | Reference divider M |
| rate_hz | output | 32 | Achieved frequency in Hz |

## Verification
The bench uses the default parameters: 32-bit frequencies, a 12-bit N, a 9-bit M and the 80 to 230 MHz window. With these settings the cases can reach both clamp edges, requests that the GCD reduces exactly, and ratios of coprime inputs that need many halving steps. A reference of 1 Hz drives M down to zero and forces it back to 1. A reference of 0 Hz makes the GCD the target itself, so the zero-forcing path is exercised with the divider dividing by the target.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_GCD,
    S_DIVN,
    S_DIVM,
    S_FIT,
    S_RATE,
    S_DONE
  } prr_state_e;
endpackage

// File: rtl/prr_window.sv
module prr_window #(
  parameter int          FW      = 32,
  parameter int unsigned VCO_MIN = 80000000,
  parameter int unsigned VCO_MAX = 230000000
) (
  input  logic [FW-1:0] req_hz,
  input  logic [FW-1:0] src_hz,
  output logic          use_bypass,
  output logic [FW-1:0] target_hz
);
  localparam logic [FW-1:0] LO = FW'(VCO_MIN);
  localparam logic [FW-1:0] HI = FW'(VCO_MAX);

  always_comb begin
    use_bypass = (req_hz <= src_hz);
    if (req_hz < LO)      target_hz = LO;
    else if (req_hz > HI) target_hz = HI;
    else                  target_hz = req_hz;
  end
endmodule

// File: rtl/prr_gcd.sv
module prr_gcd #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         fin,
  output logic [W-1:0] result
);
  localparam int KW = $clog2(W + 1);

  logic [W-1:0]  a_q, b_q;
  logic [KW-1:0] k_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      k_q    <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
      result <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !run_q) begin
        a_q   <= a_in;
        b_q   <= b_in;
        k_q   <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (a_q == '0) begin
          result <= b_q << k_q;
          run_q  <= 1'b0;
          fin    <= 1'b1;
        end else if (b_q == '0) begin
          result <= a_q << k_q;
          run_q  <= 1'b0;
          fin    <= 1'b1;
        end else if (!a_q[0] && !b_q[0]) begin
          a_q <= a_q >> 1;
          b_q <= b_q >> 1;
          k_q <= k_q + 1'b1;
        end else if (!a_q[0]) begin
          a_q <= a_q >> 1;
        end else if (!b_q[0]) begin
          b_q <= b_q >> 1;
        end else if (a_q >= b_q) begin
          a_q <= a_q - b_q;
        end else begin
          b_q <= b_q - a_q;
        end
      end
    end
  end

  // R3: every working step with both operands nonzero strictly shrinks their sum
  p_gcd_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    (run_q && a_q != '0 && b_q != '0 && !go) |=>
      ((W+1)'(a_q) + (W+1)'(b_q)) < ((W+1)'($past(a_q)) + (W+1)'($past(b_q))));
endmodule

// File: rtl/prr_divider.sv
module prr_divider #(
  parameter int DW = 44,
  parameter int VW = 32,
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          fin,
  output logic [QW-1:0] quotient
);
  localparam int CW = $clog2(DW + 1);

  logic [VW-1:0] rem_q, dsr_q;
  logic [DW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [VW:0]   trial;

  assign trial    = {rem_q, quo_q[DW-1]};
  assign quotient = quo_q[QW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dsr_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, dsr_q}) begin
          rem_q <= VW'(trial - {1'b0, dsr_q});
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= trial[VW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  // R6: restoring step keeps the partial remainder below a nonzero divisor
  p_div_rem_lt_r6: assert property (@(posedge clk) disable iff (rst)
    (fin && dsr_q != '0) |-> (rem_q < dsr_q));
endmodule

// File: rtl/pll_ratio_reducer.sv
module pll_ratio_reducer
  import prr_pkg::*;
#(
  parameter int          FW      = 32,
  parameter int          NW      = 12,
  parameter int          MW      = 9,
  parameter int unsigned VCO_MIN = 80000000,
  parameter int unsigned VCO_MAX = 230000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] req_hz,
  input  logic [FW-1:0] src_hz,
  output logic          busy,
  output logic          done,
  output logic          bypass,
  output logic [NW-1:0] n_out,
  output logic [MW-1:0] m_out,
  output logic [FW-1:0] rate_hz
);
  localparam int            DW    = FW + NW;
  localparam logic [FW-1:0] N_MAX = FW'((1 << NW) - 1);
  localparam logic [FW-1:0] M_MAX = FW'((1 << MW) - 1);

  prr_state_e    state_q;
  logic [FW-1:0] src_q, tgt_q, g_q, n_q, m_q, rate_q;
  logic          byp_q, kick_q;

  logic          byp_w;
  logic [FW-1:0] tgt_w;
  logic          gcd_go, gcd_fin;
  logic [FW-1:0] gcd_res;
  logic [DW-1:0] div_dvd;
  logic [FW-1:0] div_dsr, div_quo;
  logic          div_fin;

  prr_window #(.FW(FW), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)) u_window (
    .req_hz(req_hz), .src_hz(src_hz), .use_bypass(byp_w), .target_hz(tgt_w)
  );

  assign gcd_go = (state_q == S_IDLE) && start && !byp_w;

  prr_gcd #(.W(FW)) u_gcd (
    .clk(clk), .rst(rst), .go(gcd_go), .a_in(tgt_w), .b_in(src_hz),
    .fin(gcd_fin), .result(gcd_res)
  );

  always_comb begin
    case (state_q)
      S_DIVN:  begin div_dvd = DW'(tgt_q); div_dsr = g_q; end
      S_DIVM:  begin div_dvd = DW'(src_q); div_dsr = g_q; end
      default: begin
        div_dvd = DW'(src_q) * DW'(n_q[NW-1:0]);
        div_dsr = m_q;
      end
    endcase
  end

  prr_divider #(.DW(DW), .VW(FW), .QW(FW)) u_div (
    .clk(clk), .rst(rst), .go(kick_q), .dividend(div_dvd), .divisor(div_dsr),
    .fin(div_fin), .quotient(div_quo)
  );

  assign busy = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      tgt_q   <= '0;
      g_q     <= '0;
      n_q     <= '0;
      m_q     <= '0;
      rate_q  <= '0;
      byp_q   <= 1'b0;
      kick_q  <= 1'b0;
      done    <= 1'b0;
      bypass  <= 1'b0;
      n_out   <= '0;
      m_out   <= '0;
      rate_hz <= '0;
    end else begin
      done   <= 1'b0;
      kick_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          src_q <= src_hz;
          tgt_q <= tgt_w;
          byp_q <= byp_w;
          if (byp_w) begin
            n_q     <= '0;
            m_q     <= '0;
            rate_q  <= src_hz;
            state_q <= S_DONE;
          end else begin
            state_q <= S_GCD;
          end
        end
        S_GCD: if (gcd_fin) begin
          g_q     <= gcd_res;
          kick_q  <= 1'b1;
          state_q <= S_DIVN;
        end
        S_DIVN: if (div_fin) begin
          n_q     <= div_quo;
          kick_q  <= 1'b1;
          state_q <= S_DIVM;
        end
        S_DIVM: if (div_fin) begin
          m_q     <= div_quo;
          state_q <= S_FIT;
        end
        S_FIT: begin
          if (n_q > N_MAX || m_q > M_MAX) begin
            n_q <= n_q >> 1;
            m_q <= m_q >> 1;
          end else begin
            if (n_q == '0) n_q <= FW'(1);
            if (m_q == '0) m_q <= FW'(1);
            kick_q  <= 1'b1;
            state_q <= S_RATE;
          end
        end
        S_RATE: if (div_fin) begin
          rate_q  <= div_quo;
          state_q <= S_DONE;
        end
        S_DONE: begin
          done    <= 1'b1;
          bypass  <= byp_q;
          n_out   <= n_q[NW-1:0];
          m_out   <= m_q[MW-1:0];
          rate_hz <= rate_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_bypass_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (done && bypass) |-> (n_out == '0 && m_out == '0));

  p_clamp_window_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_GCD) |-> (tgt_q >= FW'(VCO_MIN) && tgt_q <= FW'(VCO_MAX)));

  p_gcd_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    gcd_fin |-> (gcd_res != '0));

  p_fit_range_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RATE) |-> (n_q <= N_MAX && m_q <= M_MAX));

  p_no_zero_term_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !bypass) |-> (n_out != '0 && m_out != '0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(src_q) && $stable(tgt_q)));
endmodule

// File: tb/pll_ratio_reducer_bench.sv
module pll_ratio_reducer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] req_hz = '0;
  logic [31:0] src_hz = '0;
  logic        busy, done, bypass;
  logic [11:0] n_out;
  logic [8:0]  m_out;
  logic [31:0] rate_hz;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  pll_ratio_reducer u_pll_ratio_reducer (
    .clk(clk), .rst(rst), .start(start), .req_hz(req_hz), .src_hz(src_hz),
    .busy(busy), .done(done), .bypass(bypass), .n_out(n_out), .m_out(m_out),
    .rate_hz(rate_hz)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint rq, input longint sr, output bit eb,
                       output longint en, output longint em, output longint er);
    longint t, a, b, tmp;
    if (rq <= sr) begin
      eb = 1; en = 0; em = 0; er = sr;
    end else begin
      eb = 0;
      t = (rq < 80000000) ? 80000000 : ((rq > 230000000) ? 230000000 : rq);
      a = t; b = sr;
      while (b != 0) begin tmp = a % b; a = b; b = tmp; end
      en = t / a; em = sr / a;
      while (en > 4095 || em > 511) begin en = en >> 1; em = em >> 1; end
      if (en == 0) en = 1;
      if (em == 0) em = 1;
      er = (sr * en) / em;
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_case(input longint rq, input longint sr, input string tag);
    bit eb, ok; longint en, em, er;
    model(rq, sr, eb, en, em, er);
    @(negedge clk);
    req_hz = 32'(rq); src_hz = 32'(sr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    wait_done(ok);
    check(ok, {tag, " done seen R7"}, ok, 1);
    check(bypass == eb, {tag, " bypass"}, bypass, eb);
    check(n_out == en, {tag, " N"}, n_out, en);
    check(m_out == em, {tag, " M"}, m_out, em);
    check(rate_hz == er, {tag, " rate R6"}, rate_hz, er);
    @(negedge clk);
    check(!done && !busy, "R7 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    check(n_out == en && m_out == em, "R7 outputs held", n_out, en);
  endtask

  task automatic t_reset;
    check(!busy && !done && !bypass, "R9 reset flags", {busy, done, bypass}, 0);
    check(n_out == 0 && m_out == 0 && rate_hz == 0, "R9 reset values", n_out, 0);
  endtask

  task automatic t_bypass;
    run_case(10000000, 25000000, "R1 below ref");
    run_case(27000000, 27000000, "R1 equal ref");
    run_case(0, 0, "R1 zero both");
  endtask

  task automatic t_clamp;
    run_case(20000000, 10000000, "R2 clamp low");
    check(n_out == 8 && m_out == 1, "R2 low N=8 M=1", n_out, 8);
    run_case(300000000, 25000000, "R2 clamp high");
    check(n_out == 46 && m_out == 5, "R2 high N=46 M=5", n_out, 46);
  endtask

  task automatic t_reduce;
    run_case(100000000, 27000000, "R3 gcd exact");
    check(n_out == 100 && m_out == 27 && rate_hz == 100000000, "R3 100/27", n_out, 100);
    run_case(148500000, 24576000, "R3 mixed factors");
  endtask

  task automatic t_fit;
    run_case(229999999, 27000000, "R4 coprime fit");
    run_case(123456789, 33333333, "R4 fit second");
  endtask

  task automatic t_zero_force;
    run_case(64'hFFFFFFFF, 1, "R5 ref one");
    check(m_out == 1, "R5 M forced to 1", m_out, 1);
    run_case(100000000, 0, "R5 ref zero");
    check(n_out == 1 && m_out == 1 && rate_hz == 0, "R5 both one", n_out, 1);
  endtask

  task automatic t_ignore;
    bit eb, ok, extra; longint en, em, er;
    model(100000000, 27000000, eb, en, em, er);
    @(negedge clk);
    req_hz = 100000000; src_hz = 27000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    req_hz = 5000000; src_hz = 10000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(ok && n_out == en && m_out == em && !bypass, "R8 first request kept", n_out, en);
    extra = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done || busy) extra = 1;
    end
    check(!extra, "R8 no second result", extra, 0);
  endtask

  initial begin
    #(150000 * 20);
    if (!ended) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_clamp();
    t_reduce();
    t_fit();
    t_zero_force();
    t_ignore();
    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule